// File: doc/BRIEF.md
# Dual-Channel Gated Non-Retriggerable Pulse Generator

This block is a clocked, fully digital monostable with two identical, independent channels. Each channel has two trigger inputs of opposite polarity: a falling-edge trigger (`trig_n`) and a rising-edge trigger (`trig_p`). Each trigger input also acts as an inhibit for the other one. A qualifying edge starts one high pulse on `q`, with `qn` as its complement. The pulse length is a number of clock cycles taken from a per-channel width field. That field takes the place of an analog timing network.

The trigger inputs and the clear are sampled through two-flop synchronizers, and edges are found by comparing consecutive synchronized samples. Once a pulse has started it cannot be stretched, cut short or restarted by trigger activity. Only the active-low clear, which acts at once and asynchronously, ends it early. Each pulse is followed by a fixed recovery gap of `REC` cycles, and triggers that arrive during the gap are dropped.

Top module: `dual_oneshot`

## Requirements
- R1: A falling edge on `trig_n` fires a pulse when `trig_p` is high and the clear is released.
- R2: A rising edge on `trig_p` fires a pulse when `trig_n` is low and the clear is released.
- R3: Holding `trig_p` low blocks falling edges on `trig_n`, and holding `trig_n` high blocks rising edges on `trig_p`; neither case produces a pulse.
- R4: A fired pulse keeps `q` high for exactly max(W,1) clock cycles, where W is the channel's field `pulse_w[8*ch +: 8]`. `q` is first seen high after the third rising clock edge following the input change: two synchronizer stages plus the output register.
- R5: Trigger edges on either input during a pulse neither lengthen, shorten nor restart it.
- R6: While `clr_n` is low, `q` is low and `qn` is high, with no clock needed. Asserting it during a pulse ends the pulse at once.
- R7: A trigger edge that is detected while the synchronized clear is low, or in the same cycle that it goes high, is ignored.
- R8: After `q` falls, trigger edges whose detection would start a pulse within the next `REC` cycles are ignored (default `REC` = 2). The first accepted pulse then rises `REC`+1 cycles after the fall.
- R9: `qn` is always the inverse of `q`.
- R10: The two channels have separate triggers, clears, widths and outputs, and neither affects the other.
- R11: Qualifying edges on both trigger inputs in the same cycle produce a single pulse.
- R12: During and right after the synchronous reset `rst`, `q` is low and `qn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | NCH | Falling-edge trigger per channel; high inhibits `trig_p` |
| trig_p | input | NCH | Rising-edge trigger per channel; low inhibits `trig_n` |
| clr_n | input | NCH | Active-low asynchronous clear per channel |
| pulse_w | input | NCH*WW | Pulse width in cycles per channel; channel ch uses bits [WW*ch +: WW] |
| q | output | NCH | Pulse output per channel |
| qn | output | NCH | Complementary pulse output per channel |

## Verification
The bench sweeps the width from 1 to 6 on both trigger paths. An off-by-one counter would show up there as a pulse one cycle too long or too short, and a wrong synchronizer depth would show up as a shifted start. It drives the inhibiting level on each trigger input, and it toggles both triggers during a long pulse; a design that retriggers would stretch that pulse or emit a second one. It places a second trigger one cycle inside and one cycle past the recovery gap, and it releases the clear in the same cycle as a trigger edge. A design with the wrong gap length, or one that qualifies triggers on the raw clear, would fire there. It also pulls the clear during a pulse and checks that `q` drops before the next clock edge, while the other channel keeps pulsing on its own.

// File: rtl/os_pkg.sv
`timescale 1ns/1ps
package os_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_HOLD = 2'd2
  } os_state_e;
endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
  parameter int              WIDTH = 3,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/os_trig.sv
`timescale 1ns/1ps
module os_trig (
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  input  logic clr_s,
  output logic fire_req
);
  logic a_d, b_d, clr_d;
  logic a_fall, b_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_d   <= 1'b1;
      b_d   <= 1'b0;
      clr_d <= 1'b0;
    end else begin
      a_d   <= a_s;
      b_d   <= b_s;
      clr_d <= clr_s;
    end
  end

  // each edge is qualified by the level on the opposite input
  assign a_fall   = a_d & ~a_s & b_s;
  assign b_rise   = ~b_d & b_s & ~a_s;
  // clear must be high now and on the previous sample (setup before trigger)
  assign fire_req = (a_fall | b_rise) & clr_s & clr_d;
endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
module os_timer
  import os_pkg::*;
#(
  parameter int WW  = 8,
  parameter int REC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          fire_req,
  input  logic [WW-1:0] width,
  output logic          q,
  output logic          qn
);
  localparam int RW = $clog2(REC + 2);

  os_state_e     state;
  logic [WW-1:0] cnt;
  logic [RW-1:0] rec;
  logic [WW-1:0] load_w;

  assign load_w = (width == '0) ? WW'(1) : width;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rec   <= '0;
      q     <= 1'b0;
      qn    <= 1'b1;
    end else if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rec   <= '0;
      q     <= 1'b0;
      qn    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fire_req) begin
            state <= ST_HIGH;
            cnt   <= load_w;
            q     <= 1'b1;
            qn    <= 1'b0;
          end
        end
        ST_HIGH: begin
          if (cnt == WW'(1)) begin
            q  <= 1'b0;
            qn <= 1'b1;
            if (REC == 0) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_HOLD;
              rec   <= RW'(REC);
            end
          end else begin
            cnt <= cnt - WW'(1);
          end
        end
        ST_HOLD: begin
          if (rec <= RW'(1)) state <= ST_IDLE;
          rec <= rec - RW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/os_channel.sv
`timescale 1ns/1ps
module os_channel #(
  parameter int WW  = 8,
  parameter int REC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_n,
  input  logic          b_p,
  input  logic          clr_n,
  input  logic [WW-1:0] width,
  output logic          q,
  output logic          qn
);
  logic [2:0] raw, synced;
  logic       fire_req;

  assign raw = {clr_n, b_p, a_n};

  os_sync #(.WIDTH(3), .INIT(3'b001)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  os_trig u_trig (
    .clk(clk), .rst(rst),
    .a_s(synced[0]), .b_s(synced[1]), .clr_s(synced[2]),
    .fire_req(fire_req)
  );

  os_timer #(.WW(WW), .REC(REC)) u_timer (
    .clk(clk), .rst(rst), .clr_n(clr_n),
    .fire_req(fire_req), .width(width),
    .q(q), .qn(qn)
  );
endmodule

// File: rtl/dual_oneshot.sv
`timescale 1ns/1ps
module dual_oneshot #(
  parameter int NCH = 2,
  parameter int WW  = 8,
  parameter int REC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    trig_n,
  input  logic [NCH-1:0]    trig_p,
  input  logic [NCH-1:0]    clr_n,
  input  logic [NCH*WW-1:0] pulse_w,
  output logic [NCH-1:0]    q,
  output logic [NCH-1:0]    qn
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    os_channel #(.WW(WW), .REC(REC)) u_ch (
      .clk(clk), .rst(rst),
      .a_n(trig_n[ch]), .b_p(trig_p[ch]), .clr_n(clr_n[ch]),
      .width(pulse_w[WW*ch +: WW]),
      .q(q[ch]), .qn(qn[ch])
    );
  end
endmodule

// File: rtl/dual_oneshot_chk.sv
`timescale 1ns/1ps
module dual_oneshot_chk #(
  parameter int NCH = 2,
  parameter int WW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    clr_n,
  input logic [NCH*WW-1:0] pulse_w,
  input logic [NCH-1:0]    q,
  input logic [NCH-1:0]    qn
);
  localparam int CW = WW + 1;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    logic          q_prev;
    logic [WW-1:0] w_prev;
    logic [CW-1:0] hi_cnt, wl, eff;

    always_ff @(posedge clk) begin
      if (rst) begin
        q_prev <= 1'b0;
        w_prev <= '0;
        hi_cnt <= '0;
        wl     <= CW'(1);
      end else begin
        q_prev <= q[ch];
        w_prev <= pulse_w[WW*ch +: WW];
        hi_cnt <= q[ch] ? hi_cnt + CW'(1) : '0;
        if (q[ch] && !q_prev) wl <= eff;
      end
    end

    always_comb begin
      eff = wl;
      if (q[ch] && !q_prev) eff = (w_prev == '0) ? CW'(1) : CW'(w_prev);
    end

    p_len_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (q[ch] && (hi_cnt + CW'(1) < eff) && clr_n[ch]) |=> (q[ch] || !clr_n[ch]));
    p_len_end_r4: assert property (@(posedge clk) disable iff (rst)
      (q[ch] && (hi_cnt + CW'(1) >= eff)) |=> !q[ch]);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      !clr_n[ch] |-> (!q[ch] && qn[ch]));
    p_setup_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(q[ch]) |-> ($past(clr_n[ch], 3) && $past(clr_n[ch], 4)));
    p_gap_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(q[ch]) |=> !q[ch]);
    p_compl_r9: assert property (@(posedge clk) disable iff (rst)
      qn[ch] == ~q[ch]);
  end
endmodule

bind dual_oneshot dual_oneshot_chk #(.NCH(NCH), .WW(WW)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .pulse_w(pulse_w), .q(q), .qn(qn)
);

// File: tb/test_dual_oneshot.sv
`timescale 1ns/1ps
module test_dual_oneshot;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  trig_n = 2'b11;
  logic [1:0]  trig_p = 2'b00;
  logic [1:0]  clr_n = 2'b11;
  logic [15:0] pulse_w = {8'd3, 8'd3};
  logic [1:0]  q, qn;

  int total = 0;
  int bad = 0;
  int r_rise[2], r_first[2], r_second[2], r_hi[2], r_q9[2];

  always #4 clk = ~clk;

  dual_oneshot i_dual_oneshot (
    .clk(clk), .rst(rst), .trig_n(trig_n), .trig_p(trig_p),
    .clr_n(clr_n), .pulse_w(pulse_w), .q(q), .qn(qn)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int ch, input int n);
    logic prev;
    prev = 1'b0;
    r_rise[ch] = 0; r_first[ch] = 0; r_second[ch] = 0; r_hi[ch] = 0; r_q9[ch] = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      #2;
      if (q[ch]) r_hi[ch]++;
      if (q[ch] && !prev) begin
        r_rise[ch]++;
        if (r_rise[ch] == 1) r_first[ch] = i;
        else if (r_rise[ch] == 2) r_second[ch] = i;
      end
      if (qn[ch] !== ~q[ch]) r_q9[ch]++;
      prev = q[ch];
    end
  endtask

  task automatic check_r9;
    check("R9 qn inverse ch0", r_q9[0], 0);
    check("R9 qn inverse ch1", r_q9[1], 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle(3);
    #2;
    check("R12 q in reset", int'(q), 0);
    check("R12 qn in reset", int'(qn), 3);
    settle(2);
    rst = 1'b0;
    settle(1);
    #2;
    check("R12 q after reset", int'(q), 0);
    check("R12 qn after reset", int'(qn), 3);
    settle(10);

    // R1 / R4: falling-edge path, width sweep, both channels
    for (int w = 1; w <= 6; w++) begin
      pulse_w = {8'(w), 8'(w)};
      trig_p = 2'b11;   // rising edge while trig_n high: inhibited
      settle(10);
      fork
        watch(0, 20);
        watch(1, 20);
        trig_n = 2'b00;
      join
      for (int ch = 0; ch < 2; ch++) begin
        check("R1 one pulse from falling trig_n", r_rise[ch], 1);
        check("R4 start latency", r_first[ch], 3);
        check("R4 pulse length", r_hi[ch], w);
      end
      check_r9();
      trig_n = 2'b11;
      settle(10);
    end

    // R2 / R4: rising-edge path, width sweep
    trig_p = 2'b00;
    settle(10);
    trig_n = 2'b00;
    settle(10);
    for (int w = 1; w <= 6; w++) begin
      pulse_w = {8'(w), 8'(w)};
      settle(2);
      fork
        watch(0, 20);
        watch(1, 20);
        trig_p = 2'b11;
      join
      for (int ch = 0; ch < 2; ch++) begin
        check("R2 one pulse from rising trig_p", r_rise[ch], 1);
        check("R4 start latency", r_first[ch], 3);
        check("R4 pulse length", r_hi[ch], w);
      end
      trig_p = 2'b00;
      settle(10);
    end

    // R3: mutual inhibit
    trig_n = 2'b11;
    settle(10);
    fork
      watch(0, 16);
      watch(1, 16);
      begin
        trig_n = 2'b00;   // trig_p low: blocked
        settle(3);
        trig_n = 2'b11;
        settle(3);
        trig_p = 2'b11;   // trig_n high: blocked
      end
    join
    check("R3 inhibit ch0", r_rise[0], 0);
    check("R3 inhibit ch1", r_rise[1], 0);

    // R11: simultaneous qualifying edges
    trig_p = 2'b00;
    settle(10);
    pulse_w = {8'd4, 8'd4};
    settle(2);
    fork
      watch(0, 20);
      watch(1, 20);
      begin trig_n = 2'b00; trig_p = 2'b11; end
    join
    check("R11 single pulse count", r_rise[0], 1);
    check("R11 single pulse length", r_hi[0], 4);
    check("R11 single pulse count ch1", r_rise[1], 1);
    trig_n = 2'b11;
    settle(10);

    // R5: non-retriggerable, toggling during pulse
    pulse_w = {8'd8, 8'd8};
    settle(2);
    fork
      watch(0, 24);
      watch(1, 24);
      begin
        trig_n = 2'b00;
        settle(3); trig_n = 2'b11;
        settle(1); trig_n = 2'b00;
        settle(1); trig_p = 2'b00;
        settle(1); trig_p = 2'b11;
        settle(1); trig_n = 2'b11;
        settle(1); trig_n = 2'b00;
      end
    join
    check("R5 no retrigger count", r_rise[0], 1);
    check("R5 no retrigger length", r_hi[0], 8);
    check("R5 no retrigger length ch1", r_hi[1], 8);
    check_r9();
    trig_n = 2'b11;
    settle(10);

    // R8: trigger inside the recovery gap is dropped
    pulse_w = {8'd2, 8'd2};
    settle(2);
    fork
      watch(0, 20);
      watch(1, 20);
      begin
        trig_n = 2'b00;
        settle(1); trig_n = 2'b11;
        settle(3); trig_n = 2'b00;  // would fire one cycle inside the gap
      end
    join
    check("R8 trigger in gap ignored ch0", r_rise[0], 1);
    check("R8 trigger in gap ignored ch1", r_rise[1], 1);
    trig_n = 2'b11;
    settle(10);
    // R8: trigger just past the gap is accepted
    fork
      watch(0, 20);
      watch(1, 20);
      begin
        trig_n = 2'b00;
        settle(1); trig_n = 2'b11;
        settle(4); trig_n = 2'b00;
      end
    join
    check("R8 trigger after gap count", r_rise[0], 2);
    check("R8 trigger after gap start", r_second[0], 8);
    check("R8 trigger after gap length", r_hi[0], 4);
    trig_n = 2'b11;
    settle(10);

    // R6 / R10: clear ends a pulse immediately; other channel untouched
    pulse_w = {8'd10, 8'd10};
    settle(2);
    fork
      watch(0, 30);
      watch(1, 30);
      begin
        trig_n[0] = 1'b0;
        settle(5);
        clr_n[0] = 1'b0;
        #1;
        check("R6 q drops without clock", int'(q[0]), 0);
        check("R6 qn rises without clock", int'(qn[0]), 1);
        settle(4);
        clr_n[0] = 1'b1;
      end
    join
    check("R6 clear cut pulse length", r_hi[0], 2);
    check("R6 no resume after clear", r_rise[0], 1);
    check("R10 idle channel unaffected", r_rise[1], 0);
    check_r9();
    trig_n = 2'b11;
    settle(10);

    // R7 / R10: trigger while clear low ignored; other channel fires
    clr_n[0] = 1'b0;
    settle(4);
    fork
      watch(0, 20);
      watch(1, 20);
      trig_n = 2'b00;
    join
    check("R7 trigger during clear ignored", r_rise[0], 0);
    check("R10 other channel fires", r_rise[1], 1);
    check("R10 other channel length", r_hi[1], 10);
    trig_n = 2'b11;
    settle(14);
    // R7: clear release in the same cycle as the trigger edge
    fork
      watch(0, 16);
      watch(1, 16);
      begin clr_n[0] = 1'b1; trig_n[0] = 1'b0; end
    join
    check("R7 same-cycle release ignored", r_rise[0], 0);
    trig_n = 2'b11;
    settle(10);
    fork
      watch(0, 20);
      watch(1, 20);
      trig_n[0] = 1'b0;
    join
    check("R7 trigger after setup accepted", r_rise[0], 1);
    check("R7 trigger after setup length", r_hi[0], 10);
    trig_n = 2'b11;
    settle(14);

    // R10: different widths per channel at once
    pulse_w = {8'd5, 8'd3};
    settle(2);
    fork
      watch(0, 20);
      watch(1, 20);
      trig_n = 2'b00;
    join
    check("R10 ch0 own width", r_hi[0], 3);
    check("R10 ch1 own width", r_hi[1], 5);
    check_r9();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule